// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block places one scan cell on every signal pin of a device, input pins and output pins alike. All cells are joined into a single serial path that starts at a scan data input and ends at a scan data output. A separate test access controller drives the block. It supplies a capture strobe, a shift strobe, an update strobe and a two-bit test mode. These strobes are synchronous to the test clock.

Each cell holds two stages: a shift stage on the serial path and an update stage. The update stage changes only on the update strobe. In functional mode every cell is transparent, so core outputs reach the pads and pad inputs reach the core. In the external test mode, the output-pin update stages drive the pads, which allows interconnect between chips to be tested. In the internal test mode, the input-pin update stages also drive the core inputs, which allows the core logic to be tested. In both test modes a capture loads the pad inputs and the core outputs into the shift stages, and these values are then shifted out for checking.

Top module: `bscan_chain`

## Requirements
- R1: When mode is 2'b00 (functional) or 2'b11 (reserved, treated as functional), pad_out equals core_out and core_in equals pad_in in the same cycle.
- R2: When mode is 2'b01 (external test), pad_out[j] is the update stage of output cell j and core_in equals pad_in.
- R3: When mode is 2'b10 (internal test), core_in[i] is the update stage of input cell i and pad_out[j] is the update stage of output cell j.
- R4: A clock edge with capture asserted loads input cell i with pad_in[i] and output cell j with core_out[j], in any mode.
- R5: A clock edge with shift asserted and capture low moves every shift stage one position toward scan_out. The chain order is scan_in, input cells 0 to N_IN-1, then output cells 0 to N_OUT-1. scan_out is the shift stage of output cell N_OUT-1.
- R6: When capture and shift are both asserted on the same edge, the capture takes effect and no shift happens.
- R7: An update stage changes only on an edge with the update strobe asserted. On that edge it takes the value its shift stage held before the edge. Pins driven from update stages therefore stay steady while shifting.
- R8: After reset, all shift stages and update stages are zero.
- R9: On an edge with neither capture nor shift asserted, every shift stage keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 functional, 01 external test, 10 internal test, 11 functional |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| scan_in | input | 1 | Serial scan data input |
| scan_out | output | 1 | Serial scan data output |
| pad_in | input | N_IN | Values present at input pads |
| core_in | output | N_IN | Values delivered to core inputs |
| core_out | input | N_OUT | Values produced by core outputs |
| pad_out | output | N_OUT | Values driven onto output pads |

## Verification
Two pairs of functions can land on the same edge.

The first pair is capture and shift. The bench raises both strobes for one edge while the pads and core outputs present a known pattern. It then unloads the whole chain. The result is judged against the captured pattern, not against a one-position-shifted copy of it.

The second pair is update and shift. The bench raises both strobes for one edge after loading a pattern. The pads must then show the pattern as it stood before that edge. They must stay unchanged through the shifts that follow.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

   typedef enum logic [1:0] {
      BS_FUNC = 2'b00,
      BS_EXT  = 2'b01,
      BS_INT  = 2'b10,
      BS_RSVD = 2'b11
   } bscan_mode_e;

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic cap_en,
   input  logic shift_en,
   input  logic upd_en,
   input  logic cap_d,
   input  logic ser_in,
   output logic shift_q,
   output logic upd_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        shift_q <= 1'b0;
      else if (cap_en)   shift_q <= cap_d;
      else if (shift_en) shift_q <= ser_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      upd_q <= 1'b0;
      else if (upd_en) upd_q <= shift_q;
   end

   // R4 R6
   cap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> shift_q == $past(cap_d));

   // R5
   shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !cap_en) |=> shift_q == $past(ser_in));

   // R9
   shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en && !cap_en) |=> $stable(shift_q));

   // R7
   upd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(upd_q));

   // R7
   upd_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> upd_q == $past(shift_q));

endmodule

// File: rtl/bscan_mode_dec.sv
module bscan_mode_dec #(
   parameter bit INT_DRIVES_PADS = 1'b1
) (
   input  logic [1:0] mode,
   output logic       drive_pads,
   output logic       drive_core
);
   import bscan_pkg::*;

   bscan_mode_e m;
   logic        is_ext, is_int;

   assign m      = bscan_mode_e'(mode);
   assign is_ext = (m == BS_EXT);
   assign is_int = (m == BS_INT);
   assign drive_core = is_int;

   generate
      if (INT_DRIVES_PADS) begin : g_safe_pads
         assign drive_pads = is_ext | is_int;
      end else begin : g_live_pads
         assign drive_pads = is_ext;
      end
   endgenerate

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
   parameter int N_IN            = 6,
   parameter int N_OUT           = 5,
   parameter bit INT_DRIVES_PADS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             capture_en,
   input  logic             shift_en,
   input  logic             update_en,
   input  logic             scan_in,
   output logic             scan_out,
   input  logic [N_IN-1:0]  pad_in,
   output logic [N_IN-1:0]  core_in,
   input  logic [N_OUT-1:0] core_out,
   output logic [N_OUT-1:0] pad_out
);

   localparam int N_TOT = N_IN + N_OUT;

   generate
      if (N_IN < 1)  begin : g_bad_in  $error("bscan_chain: N_IN must be at least 1"); end
      if (N_OUT < 1) begin : g_bad_out $error("bscan_chain: N_OUT must be at least 1"); end
   endgenerate

   logic [N_TOT-1:0] cap_vec;
   logic [N_TOT-1:0] sh_q;
   logic [N_TOT-1:0] up_q;
   logic             drive_pads, drive_core;

   assign cap_vec = {core_out, pad_in};

   bscan_mode_dec #(.INT_DRIVES_PADS(INT_DRIVES_PADS)) u_dec (
      .mode       (mode),
      .drive_pads (drive_pads),
      .drive_core (drive_core)
   );

   genvar k;
   generate
      for (k = 0; k < N_TOT; k++) begin : g_cell
         logic ser;
         if (k == 0) begin : g_head
            assign ser = scan_in;
         end else begin : g_link
            assign ser = sh_q[k-1];
         end
         bscan_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_en   (capture_en),
            .shift_en (shift_en),
            .upd_en   (update_en),
            .cap_d    (cap_vec[k]),
            .ser_in   (ser),
            .shift_q  (sh_q[k]),
            .upd_q    (up_q[k])
         );
      end
   endgenerate

   assign scan_out = sh_q[N_TOT-1];
   assign pad_out  = drive_pads ? up_q[N_TOT-1:N_IN] : core_out;
   assign core_in  = drive_core ? up_q[N_IN-1:0]     : pad_in;

   // R5
   tail_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !capture_en) |=> scan_out == $past(sh_q[N_TOT-2]));

   // R4
   tail_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture_en |=> scan_out == $past(core_out[N_OUT-1]));

   // R7
   pads_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_pads && !update_en) |=> (!drive_pads || $stable(pad_out)));

   // R7
   core_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_core && !update_en) |=> (!drive_core || $stable(core_in)));

endmodule

// File: tb/tb_bscan_chain.sv
module tb_bscan_chain;

   localparam int NI = 6;
   localparam int NO = 5;
   localparam int NT = NI + NO;
   localparam int NV = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode = 2'b00;
   logic          capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0;
   logic          scan_in = 1'b0;
   logic          scan_out;
   logic [NI-1:0] pad_in = '0;
   logic [NI-1:0] core_in;
   logic [NO-1:0] core_out = '0;
   logic [NO-1:0] pad_out;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bscan_chain #(.N_IN(NI), .N_OUT(NO)) dut (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
      .scan_in(scan_in), .scan_out(scan_out),
      .pad_in(pad_in), .core_in(core_in),
      .core_out(core_out), .pad_out(pad_out)
   );

   localparam logic [1:0]    VMODE [NV] = '{2'b01, 2'b10, 2'b00, 2'b11, 2'b10};
   localparam logic [NI-1:0] VPAD  [NV] = '{6'b101100, 6'b010011, 6'b111000, 6'b000111, 6'b110101};
   localparam logic [NO-1:0] VCORE [NV] = '{5'b10011, 5'b01101, 5'b11010, 5'b00101, 5'b01110};
   localparam logic [NT-1:0] VLOAD [NV] = '{11'b10110011010, 11'b01001110101, 11'b11100011000,
                                            11'b00011101111, 11'b10101010110};

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(string req, logic [63:0] got, logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
      end
   endtask

   task automatic load(logic [NT-1:0] p);
      for (int b = NT - 1; b >= 0; b--) begin
         scan_in  = p[b];
         shift_en = 1'b1;
         tick();
      end
      shift_en = 1'b0;
      scan_in  = 1'b0;
   endtask

   task automatic unload(output logic [NT-1:0] got);
      for (int i = 0; i < NT; i++) begin
         got[NT-1-i] = scan_out;
         shift_en = 1'b1;
         tick();
      end
      shift_en = 1'b0;
   endtask

   task automatic pulse_update();
      update_en = 1'b1;
      tick();
      update_en = 1'b0;
   endtask

   task automatic pulse_capture();
      capture_en = 1'b1;
      tick();
      capture_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [NT-1:0] got;
      logic [NO-1:0] ep;
      logic [NI-1:0] ec;
      bit            pads_test, core_test;

      repeat (3) @(negedge clk);
      pad_in   = 6'b100101;
      core_out = 5'b01011;
      @(negedge clk);
      // R8 R1: reset state
      check("R8 scan_out", scan_out, 0);
      check("R1 pad_out in reset", pad_out, 5'b01011);
      rst_n = 1'b1;
      tick();
      mode = 2'b01;
      @(negedge clk);
      check("R8 update stages zero", pad_out, 0);
      mode = 2'b10;
      @(negedge clk);
      check("R8 core_in zero", core_in, 0);
      mode = 2'b00;

      // table walk
      for (int v = 0; v < NV; v++) begin
         mode     = VMODE[v];
         pad_in   = VPAD[v];
         core_out = VCORE[v];
         load(VLOAD[v]);
         pulse_update();
         pads_test = (VMODE[v] == 2'b01) || (VMODE[v] == 2'b10);
         core_test = (VMODE[v] == 2'b10);
         ep = pads_test ? VLOAD[v][NT-1:NI] : VCORE[v];
         ec = core_test ? VLOAD[v][NI-1:0]  : VPAD[v];
         // R1 R2 R3
         check(pads_test ? "R2 R3 pad_out" : "R1 pad_out", pad_out, ep);
         check(core_test ? "R3 core_in" : "R1 R2 core_in", core_in, ec);
         pulse_capture();
         // R4
         check("R4 first captured bit", scan_out, VCORE[v][NO-1]);
         unload(got);
         // R4 R5
         check("R4 R5 unloaded chain", got, {VCORE[v], VPAD[v]});
      end

      // R5: a bit shifted in emerges after NT edges
      mode = 2'b00;
      load('0);
      scan_in = 1'b1; shift_en = 1'b1; tick(); scan_in = 1'b0;
      for (int i = 0; i < NT - 2; i++) tick();
      check("R5 one short of length", scan_out, 0);
      tick();
      shift_en = 1'b0;
      check("R5 chain length", scan_out, 1);

      // R6: capture and shift together
      pad_in = 6'b011010; core_out = 5'b10110;
      load(11'b01010101010);
      capture_en = 1'b1; shift_en = 1'b1; tick();
      capture_en = 1'b0; shift_en = 1'b0;
      unload(got);
      check("R6 capture wins", got, {5'b10110, 6'b011010});

      // R7: update on the same edge as a shift takes the pre-edge value
      mode = 2'b01;
      load(11'b11001100110);
      update_en = 1'b1; shift_en = 1'b1; scan_in = 1'b1; tick();
      update_en = 1'b0;
      check("R7 update with shift", pad_out, 5'b11001);
      for (int i = 0; i < 4; i++) tick();
      shift_en = 1'b0; scan_in = 1'b0;
      check("R7 pads steady while shifting", pad_out, 5'b11001);

      // R7: internal mode core pins steady through capture
      mode = 2'b10;
      load(11'b00000101101);
      pulse_update();
      pad_in = 6'b111111;
      pulse_capture();
      check("R7 core_in steady on capture", core_in, 6'b101101);

      // R9: idle edges keep the chain
      load(11'b10011100101);
      for (int i = 0; i < 5; i++) tick();
      unload(got);
      check("R9 hold without strobes", got, 11'b10011100101);

      // R1: reserved code acts functional even with loaded update stages
      mode = 2'b11;
      pad_in = 6'b001011; core_out = 5'b11100;
      @(negedge clk);
      check("R1 reserved pad_out", pad_out, 5'b11100);
      check("R1 reserved core_in", core_in, 6'b001011);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule